// File: doc/BRIEF.md
# SDRAM Power-Up and Refresh Sequencer

This block drives the command pins of a four-bank single-data-rate SDRAM. It brings the device from power-up into normal operation and then keeps refresh going. After reset it holds NOP for a programmable settling window with clock enable high. It then issues one precharge-all. Next it issues a parameter-set number of auto-refresh commands, each separated by the row-cycle gap. It finishes the bring-up with a mode register set, whose value is built from configuration inputs. A settling gap after that command, it raises a ready flag.

In normal operation an interval timer marks each refresh slot. Twelve-bit rows refreshed 4096 times per 64 ms give one slot about every 15.6 µs, which sets the default period. A pending slot is shown to the host as a request. The sequencer inserts the auto-refresh when the host grants the bus. If a further slot expires while one is still pending, the block counts it as missed. The missed count saturates at a parameter limit. While any slot is missed, refresh is issued without waiting for a grant.

Top module: `sdr_pwrup_refresh_seq`

## Requirements
- R1: While reset is low, and in the first cycle after it, the pins show NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), bank and address zero, `init_done`=0, `ref_req`=0 and `ref_owed`=0.
- R2: After reset is released, NOP is held for exactly STABLE_CYC cycles.
- R3: In the cycle after the R2 window, precharge-all is driven for one cycle: cs_n=0, ras_n=0, cas_n=1, we_n=0, address bit 10 = 1, all other address bits and the bank zero.
- R4: INIT_REFS auto-refresh commands follow (cs_n=0, ras_n=0, cas_n=0, we_n=1, bank and address zero). The first comes TRP_CYC cycles after precharge-all, and the rest are TRC_CYC cycles apart.
- R5: TRC_CYC cycles after the last bring-up refresh, a mode register set (all four strobes 0) is driven with bank=00 and this address: [2:0]=`cfg_burst_len`, [3]=`cfg_interleave`, [6:4]=`cfg_cas_lat`, [8:7]=00, [9]=`cfg_write_single`, [11:10]=00.
- R6: `init_done` rises TMRD_CYC cycles after the mode register set and stays high until reset.
- R7: `sd_cke` is 1 in every cycle, reset included.
- R8: Once `init_done` is high, a refresh slot expires every REF_PERIOD cycles, counted from the cycle `init_done` rose. An expiring slot with none pending raises `ref_req`.
- R9: With `ref_req`=1 and `ref_owed`=0, an auto-refresh is driven in the cycle after a clock edge where `ref_grant`=1. This happens only if no normal refresh was driven in the TRC_CYC cycles before that edge. Doing so clears `ref_req`, unless a slot expires on the same edge. `ref_grant` has no effect when `ref_req`=0 or before `init_done`.
- R10: A slot expiring while `ref_req`=1 increments `ref_owed`, which saturates at MISS_MAX. While `ref_owed`>0, refresh is issued without a grant, under the R9 spacing. Each such refresh decrements `ref_owed` before `ref_req` is cleared. A refresh and an expiry on the same edge cancel out.
- R11: In every cycle not named in R3 to R5, R9 and R10, the pins show NOP with bank and address zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_burst_len | input | 3 | Burst length code for the mode register |
| cfg_interleave | input | 1 | Burst ordering select for the mode register |
| cfg_cas_lat | input | 3 | CAS latency code for the mode register |
| cfg_write_single | input | 1 | Single-word write select for the mode register |
| ref_grant | input | 1 | Host grants the bus for a refresh |
| ref_req | output | 1 | A refresh slot is pending |
| ref_owed | output | MW = $clog2(MISS_MAX+1) | Count of missed refresh slots |
| init_done | output | 1 | Bring-up finished, normal operation |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Address bus |

## Verification
The assertions assume the following about parameters:
- TRP_CYC, TRC_CYC and TMRD_CYC are at least 2, so a refresh is always followed by a NOP.
- STABLE_CYC and REF_PERIOD are at least 2.
- The configuration inputs are steady from reset release to the mode register set.

The bench keeps to these rules. It changes the configuration only while reset is held. It uses a refresh period shorter than the refresh spacing, so missed slots pile up to saturation. It holds the grant high during bring-up and during idle stretches to show that the grant is ignored there.

// File: rtl/sdr_seq_pkg.sv
// Shared command encodings, phase type and mode word builder for the
// power-up and refresh sequencer. Assumes a single-data-rate SDRAM with
// active-low command strobes.
package sdr_seq_pkg;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } sdr_cmd_t;

    localparam sdr_cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam sdr_cmd_t CMD_PALL = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam sdr_cmd_t CMD_REF  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam sdr_cmd_t CMD_MRS  = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    typedef enum logic [2:0] {
        PH_SETTLE,
        PH_AFTER_PALL,
        PH_AFTER_REF,
        PH_AFTER_MRS,
        PH_IDLE,
        PH_BUSY
    } seq_phase_t;

    localparam int ADDR_W = 12;
    localparam int BANK_W = 2;
    localparam int MODE_W = ADDR_W + BANK_W;

    // Packs the mode word as {bank, address}; test and reserved bits stay 0.
    function automatic logic [MODE_W-1:0] mk_mode(input logic [2:0] blen,
                                                  input logic       intl,
                                                  input logic [2:0] clat,
                                                  input logic       wsingle);
        logic [MODE_W-1:0] w;
        w      = '0;
        w[2:0] = blen;
        w[3]   = intl;
        w[6:4] = clat;
        w[9]   = wsingle;
        return w;
    endfunction

endpackage

// File: rtl/sdr_refresh_tracker.sv
// Refresh slot timer with pending flag and saturating missed-slot count.
// Assumes REF_PERIOD >= 2 and that 'issue' is only raised while 'pend' is 1.
module sdr_refresh_tracker #(
    parameter int REF_PERIOD = 1560,
    parameter int MISS_MAX   = 8,
    localparam int TW = (REF_PERIOD > 2) ? $clog2(REF_PERIOD) : 1,
    localparam int MW = $clog2(MISS_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          issue,
    output logic          pend,
    output logic [MW-1:0] missed
);

    localparam logic [TW-1:0] T_LAST = TW'(REF_PERIOD - 1);
    localparam logic [MW-1:0] M_LAST = MW'(MISS_MAX);

    logic [TW-1:0] tcnt;
    logic          tick;

    assign tick = run && (tcnt == T_LAST);

    // Free-running slot timer, active once bring-up has finished.
    always_ff @(posedge clk) begin
        if (!rst_n)      tcnt <= '0;
        else if (tick)   tcnt <= '0;
        else if (run)    tcnt <= tcnt + 1'b1;
    end

    // Pending flag and missed-slot count; an expiry and a refresh cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend   <= 1'b0;
            missed <= '0;
        end else if (tick && !issue) begin
            if (!pend)                 pend   <= 1'b1;
            else if (missed != M_LAST) missed <= missed + 1'b1;
        end else if (issue && !tick) begin
            if (missed != '0) missed <= missed - 1'b1;
            else              pend   <= 1'b0;
        end
    end

    // R10
    miss_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        missed <= M_LAST);

    // R10
    miss_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (missed != '0) |-> pend);

endmodule

// File: rtl/sdr_cmd_sequencer.sv
// Command sequencer: settle window, precharge-all, bring-up refreshes,
// mode register set, then refresh insertion on request. All pin values
// are registered. Assumes every gap parameter is >= 2 and INIT_REFS >= 1.
module sdr_cmd_sequencer
    import sdr_seq_pkg::*;
#(
    parameter int STABLE_CYC = 20000,
    parameter int TRP_CYC    = 3,
    parameter int TRC_CYC    = 10,
    parameter int TMRD_CYC   = 2,
    parameter int INIT_REFS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_word,
    input  logic              pend,
    input  logic              urgent,
    input  logic              grant,
    output sdr_cmd_t          cmd,
    output logic [BANK_W-1:0] ba,
    output logic [ADDR_W-1:0] addr,
    output logic              done,
    output logic              issue
);

    localparam int G1   = (STABLE_CYC > TRP_CYC) ? STABLE_CYC : TRP_CYC;
    localparam int G2   = (TRC_CYC > TMRD_CYC) ? TRC_CYC : TMRD_CYC;
    localparam int GMAX = (G1 > G2) ? G1 : G2;
    localparam int CW   = $clog2(GMAX + 1);
    localparam int RW   = $clog2(INIT_REFS + 1);

    localparam logic [CW-1:0] L_SETTLE = CW'(STABLE_CYC - 1);
    localparam logic [CW-1:0] L_RP     = CW'(TRP_CYC - 1);
    localparam logic [CW-1:0] L_RC     = CW'(TRC_CYC - 1);
    localparam logic [CW-1:0] L_MRD    = CW'(TMRD_CYC - 1);
    localparam logic [RW-1:0] R_LAST   = RW'(INIT_REFS);

    seq_phase_t    phase;
    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic [RW-1:0] refs;
    logic          gap_end;

    // Selects the gap length that ends the current waiting phase.
    always_comb begin
        case (phase)
            PH_SETTLE:     lim = L_SETTLE;
            PH_AFTER_PALL: lim = L_RP;
            PH_AFTER_MRS:  lim = L_MRD;
            default:       lim = L_RC;
        endcase
    end

    assign gap_end = (cnt == lim);
    assign issue   = (phase == PH_IDLE) && pend && (grant || urgent);

    // Phase walk and registered command pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_SETTLE;
            cnt   <= '0;
            refs  <= '0;
            cmd   <= CMD_NOP;
            ba    <= '0;
            addr  <= '0;
            done  <= 1'b0;
        end else begin
            cmd  <= CMD_NOP;
            ba   <= '0;
            addr <= '0;
            cnt  <= cnt + 1'b1;
            case (phase)
                PH_SETTLE: if (gap_end) begin
                    cmd      <= CMD_PALL;
                    addr[10] <= 1'b1;
                    cnt      <= '0;
                    phase    <= PH_AFTER_PALL;
                end
                PH_AFTER_PALL: if (gap_end) begin
                    cmd   <= CMD_REF;
                    refs  <= RW'(1);
                    cnt   <= '0;
                    phase <= PH_AFTER_REF;
                end
                PH_AFTER_REF: if (gap_end) begin
                    cnt <= '0;
                    if (refs == R_LAST) begin
                        cmd         <= CMD_MRS;
                        {ba, addr}  <= mode_word;
                        phase       <= PH_AFTER_MRS;
                    end else begin
                        cmd  <= CMD_REF;
                        refs <= refs + 1'b1;
                    end
                end
                PH_AFTER_MRS: if (gap_end) begin
                    done  <= 1'b1;
                    cnt   <= '0;
                    phase <= PH_IDLE;
                end
                PH_IDLE: begin
                    cnt <= '0;
                    if (issue) begin
                        cmd   <= CMD_REF;
                        phase <= PH_BUSY;
                    end
                end
                PH_BUSY: if (gap_end) begin
                    cnt   <= '0;
                    phase <= PH_IDLE;
                end
                default: phase <= PH_SETTLE;
            endcase
        end
    end

    // R11
    ref_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_REF) |=> (cmd == CMD_NOP));

    // R6
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    // R3
    pall_only_bringup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_PALL) |-> !done);

    // R5
    mrs_only_bringup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_MRS) |-> !done);

endmodule

// File: rtl/sdr_pwrup_refresh_seq.sv
// Top level: joins the command sequencer with the refresh tracker and
// maps the command structure onto SDRAM pins. Clock enable is held high.
module sdr_pwrup_refresh_seq
    import sdr_seq_pkg::*;
#(
    parameter int STABLE_CYC = 20000,
    parameter int TRP_CYC    = 3,
    parameter int TRC_CYC    = 10,
    parameter int TMRD_CYC   = 2,
    parameter int INIT_REFS  = 8,
    parameter int REF_PERIOD = 1560,
    parameter int MISS_MAX   = 8,
    localparam int MW = $clog2(MISS_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    cfg_burst_len,
    input  logic          cfg_interleave,
    input  logic [2:0]    cfg_cas_lat,
    input  logic          cfg_write_single,
    input  logic          ref_grant,
    output logic          ref_req,
    output logic [MW-1:0] ref_owed,
    output logic          init_done,
    output logic          sd_cke,
    output logic          sd_cs_n,
    output logic          sd_ras_n,
    output logic          sd_cas_n,
    output logic          sd_we_n,
    output logic [1:0]    sd_ba,
    output logic [11:0]   sd_addr
);

    sdr_cmd_t          cmd;
    logic              pend;
    logic [MW-1:0]     missed;
    logic              issue;
    logic              done;
    logic [MODE_W-1:0] mode_word;

    assign mode_word = mk_mode(cfg_burst_len, cfg_interleave, cfg_cas_lat, cfg_write_single);

    sdr_cmd_sequencer #(
        .STABLE_CYC (STABLE_CYC),
        .TRP_CYC    (TRP_CYC),
        .TRC_CYC    (TRC_CYC),
        .TMRD_CYC   (TMRD_CYC),
        .INIT_REFS  (INIT_REFS)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_word (mode_word),
        .pend      (pend),
        .urgent    (missed != '0),
        .grant     (ref_grant),
        .cmd       (cmd),
        .ba        (sd_ba),
        .addr      (sd_addr),
        .done      (done),
        .issue     (issue)
    );

    sdr_refresh_tracker #(
        .REF_PERIOD (REF_PERIOD),
        .MISS_MAX   (MISS_MAX)
    ) u_trk (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (done),
        .issue  (issue),
        .pend   (pend),
        .missed (missed)
    );

    assign sd_cke    = 1'b1;
    assign sd_cs_n   = cmd.cs_n;
    assign sd_ras_n  = cmd.ras_n;
    assign sd_cas_n  = cmd.cas_n;
    assign sd_we_n   = cmd.we_n;
    assign ref_req   = pend;
    assign ref_owed  = missed;
    assign init_done = done;

    // R9
    issue_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> (pend && done));

endmodule

// File: tb/test_sdr_pwrup_refresh_seq.sv
module test_sdr_pwrup_refresh_seq;

    localparam int CLK_PERIOD = 10;
    localparam int P_STABLE = 12;
    localparam int P_TRP    = 3;
    localparam int P_TRC    = 6;
    localparam int P_TMRD   = 2;
    localparam int P_NREF   = 3;
    localparam int P_PERIOD = 5;
    localparam int P_MISS   = 8;
    localparam int OW       = $clog2(P_MISS + 1);

    localparam int S_EDGE = P_STABLE;
    localparam int M_EDGE = P_STABLE + P_TRP + P_NREF * P_TRC;
    localparam int D_EDGE = M_EDGE + P_TMRD;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] blen = 3'b010;
    logic intl = 1'b0;
    logic [2:0] clat = 3'b011;
    logic wsgl = 1'b0;
    logic gnt = 1'b0;
    logic ref_req, init_done, sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [OW-1:0] ref_owed;
    logic [1:0] sd_ba;
    logic [11:0] sd_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    sdr_pwrup_refresh_seq #(
        .STABLE_CYC(P_STABLE), .TRP_CYC(P_TRP), .TRC_CYC(P_TRC), .TMRD_CYC(P_TMRD),
        .INIT_REFS(P_NREF), .REF_PERIOD(P_PERIOD), .MISS_MAX(P_MISS)
    ) i_sdr_pwrup_refresh_seq (
        .clk(clk), .rst_n(rst_n), .cfg_burst_len(blen), .cfg_interleave(intl),
        .cfg_cas_lat(clat), .cfg_write_single(wsgl), .ref_grant(gnt),
        .ref_req(ref_req), .ref_owed(ref_owed), .init_done(init_done),
        .sd_cke(sd_cke), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n),
        .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr)
    );

    int vectors = 0;
    int fails = 0;

    // Reference model state
    int    n = 0;
    int    pend_m = 0;
    int    miss_m = 0;
    int    last_e = -1000;
    bit    valid = 0;
    bit    in_rst = 1;
    logic [3:0]  e_cmd = 4'b0111;
    logic [13:0] e_bank_addr = '0;
    bit    e_done = 0;
    string e_tag = "R1";

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s at time %0t: actual %0h expected %0h", tag, $time, act, exp);
        end
    endtask

    always @(posedge clk) begin
        bit iss, tick;
        valid = 1;
        if (!rst_n) begin
            n = 0; pend_m = 0; miss_m = 0; last_e = -1000;
            e_cmd = 4'b0111; e_bank_addr = '0; e_done = 0; in_rst = 1; e_tag = "R1";
        end else begin
            n++;
            in_rst = 0;
            e_cmd = 4'b0111; e_bank_addr = '0;
            e_tag = (n < S_EDGE) ? "R2" : "R11";
            if (n == S_EDGE) begin
                e_cmd = 4'b0010; e_bank_addr = 14'h0400; e_tag = "R3";
            end else if (n >= S_EDGE + P_TRP && n < M_EDGE && ((n - S_EDGE - P_TRP) % P_TRC) == 0) begin
                e_cmd = 4'b0001; e_tag = "R4";
            end else if (n == M_EDGE) begin
                e_cmd = 4'b0000; e_tag = "R5";
                e_bank_addr = {4'b0000, wsgl, 2'b00, clat, intl, blen};
            end
            e_done = (n >= D_EDGE);
            if (n > D_EDGE) begin
                iss  = (n >= last_e + P_TRC + 1) && (pend_m != 0) && (gnt || miss_m > 0);
                tick = ((n - D_EDGE) % P_PERIOD) == 0;
                if (tick && !iss) begin
                    if (pend_m == 0) pend_m = 1;
                    else if (miss_m < P_MISS) miss_m++;
                end else if (iss && !tick) begin
                    if (miss_m > 0) miss_m--;
                    else pend_m = 0;
                end
                if (iss) begin
                    e_cmd = 4'b0001; last_e = n; e_tag = "R9";
                end
            end
        end
    end

    always @(negedge clk) begin
        if (valid) begin
            check(e_tag, {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, e_cmd);
            check(e_tag, {sd_ba, sd_addr}, e_bank_addr);
            check("R7", sd_cke, 1);
            check(in_rst ? "R1" : "R6", init_done, e_done);
            check(in_rst ? "R1" : "R8", ref_req, pend_m);
            check(in_rst ? "R1" : "R10", ref_owed, miss_m);
        end
    end

    task automatic cycles(input int k);
        repeat (k) @(negedge clk);
    endtask

    initial begin
        // R1: reset state under configuration A
        cycles(4);
        rst_n = 1'b1;
        // R2..R6: bring-up with grant low; request waits, then misses force refresh (R10)
        cycles(D_EDGE + 12);
        // R9: grant held high, refresh follows each request
        gnt = 1'b1;
        cycles(40);
        // R10: grant low long enough to saturate the missed count
        gnt = 1'b0;
        cycles(320);
        // R9: alternating grant pattern
        for (int i = 0; i < 30; i++) begin
            gnt = i[0];
            cycles(3);
        end
        // R1/R5: reset mid-run, configuration B; grant high during bring-up is ignored (R9)
        rst_n = 1'b0;
        blen = 3'b111; intl = 1'b1; clat = 3'b010; wsgl = 1'b1;
        gnt = 1'b1;
        cycles(3);
        rst_n = 1'b1;
        cycles(D_EDGE + 60);
        gnt = 1'b0;
        cycles(60);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule